// File: doc/BRIEF.md
# Hardware Priority Task Scheduler

This block is the scheduling core of a hardware real-time kernel. It holds the state of up to sixteen tasks. Each task is waiting, ready or running, and each has a three-bit priority. The block continuously picks the most urgent task that is ready or running. When that pick differs from the task the CPU is executing, it raises a single task-switch interrupt. That interrupt is the only one the CPU ever receives.

Interrupt service routines are ordinary tasks. Each of eight external interrupt pins can be bound to a task ID. A rising edge on a bound pin moves its task from waiting to ready. From then on the task competes under the same priority rule as every other task.

The CPU drives the block through a small command port. It can create a task with a priority, put the running task to sleep, bind a pin, read the next task ID, and acknowledge a switch.

Top module: `hw_task_sched`

## Requirements
- R1: After reset every task is waiting, no interrupt pin is bound, `idle_o` is 1, `switch_irq_o` is 0 and `run_valid_o` is 0.
- R2: Command code 1 (create) puts task `cmd_task_i` into the ready state with priority `cmd_arg_i`. A ready task with nothing running raises `switch_irq_o` in the cycle after the command.
- R3: The chosen task is the ready or running task with the largest priority value. Between equal priorities, the lower task ID is chosen.
- R4: Command code 4 (read) loads `rd_data_o` on the next clock edge. Bit 4 holds the idle flag and bits 3:0 hold the chosen task ID.
- R5: Command code 5 (acknowledge), issued while `switch_irq_o` is 1, makes the chosen task running and shows it on `run_task_o` with `run_valid_o`=1. A previously running task that has not issued a wait returns to ready.
- R6: Command code 2 (wait) moves the running task to waiting and clears `run_valid_o`. If no other task is ready, `idle_o` becomes 1.
- R7: Command code 3 (bind) ties interrupt pin `cmd_arg_i` to task `cmd_task_i`. Each pin passes through a two-flop synchroniser. A rising edge on a bound pin makes its waiting task ready within three clock edges. Edges on unbound pins have no effect.
- R8: A rising edge that arrives while the bound task is ready or running is held as pending. When that task next issues a wait, it goes to ready instead of waiting.
- R9: `switch_irq_o` is 1 exactly when some task is ready or running and the chosen task is not the running one. A higher-priority task woken by a pin therefore preempts the running task.
- R10: A pin held high produces one event only. After its task waits again, no new wake-up occurs until the pin falls and rises.
- R11: `switch_irq_o` is never 1 while `idle_o` is 1. An acknowledge issued while `switch_irq_o` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | External interrupt pins, asynchronous |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command code: 1 create, 2 wait, 3 bind, 4 read, 5 acknowledge |
| cmd_task_i | input | 4 | Task ID operand |
| cmd_arg_i | input | 3 | Priority for create, pin index for bind |
| rd_data_o | output | 5 | Read result: {idle, next task ID} |
| switch_irq_o | output | 1 | Task-switch interrupt to the CPU |
| idle_o | output | 1 | No task is ready or running |
| run_task_o | output | 4 | ID of the running task |
| run_valid_o | output | 1 | `run_task_o` names a task that is running |

## Verification
The bench sets up two tasks of equal priority. A design that compared with greater-or-equal would pick the higher ID. It fires an edge at a task that is already running. A design without the pending latch would lose that wake-up, and the task would sleep on its wait. It holds a pin high across a wait. A level-sensitive design would wake the task again at once. It also fires an unbound pin and acknowledges with no switch pending. A design that let either through would create a running task or a wake-up out of nothing.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2
  } task_state_e;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CREATE = 3'd1,
    OP_WAIT   = 3'd2,
    OP_BIND   = 3'd3,
    OP_READ   = 3'd4,
    OP_ACK    = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] rise_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= irq_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 16,
  parameter int PW = 3,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic [TW-1:0]   best_o,
  output logic            found_o
);
  logic [PW-1:0] best_prio;

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    found_o   = 1'b0;
    best_o    = '0;
    best_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || prio_i[i*PW +: PW] > best_prio)) begin
        found_o   = 1'b1;
        best_o    = i[TW-1:0];
        best_prio = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/hw_task_sched.sv
module hw_task_sched
  import sched_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int NUM_PRIO  = 8,
  parameter int NUM_IRQ   = 8,
  parameter int TASK_W    = $clog2(NUM_TASKS),
  parameter int PRIO_W    = $clog2(NUM_PRIO),
  parameter int IRQ_W     = $clog2(NUM_IRQ),
  parameter int ARG_W     = (PRIO_W > IRQ_W) ? PRIO_W : IRQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [TASK_W-1:0] cmd_task_i,
  input  logic [ARG_W-1:0]  cmd_arg_i,
  output logic [TASK_W:0]   rd_data_o,
  output logic              switch_irq_o,
  output logic              idle_o,
  output logic [TASK_W-1:0] run_task_o,
  output logic              run_valid_o
);
  task_state_e         state_q [NUM_TASKS];
  task_state_e         state_d [NUM_TASKS];
  logic [PRIO_W-1:0]   prio_q  [NUM_TASKS];
  logic [PRIO_W-1:0]   prio_d  [NUM_TASKS];
  logic [NUM_TASKS-1:0] pend_q, pend_d;
  logic [TASK_W-1:0]   bind_q  [NUM_IRQ];
  logic [TASK_W-1:0]   bind_d  [NUM_IRQ];
  logic [NUM_IRQ-1:0]  bvld_q, bvld_d;
  logic [TASK_W-1:0]   run_id_q, run_id_d;
  logic                run_v_q, run_v_d;
  logic [TASK_W:0]     rd_q;

  logic [NUM_IRQ-1:0]        rise;
  logic [NUM_TASKS-1:0]      cand;
  logic [NUM_TASKS*PRIO_W-1:0] prio_flat;
  logic [TASK_W-1:0]         best_id;
  logic                      best_found;
  logic                      do_switch;

  irq_edge_sync #(.NUM_IRQ(NUM_IRQ)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .rise_o(rise)
  );

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_cand
    assign cand[g] = (state_q[g] != ST_WAIT);
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  prio_pick #(.N(NUM_TASKS), .PW(PRIO_W), .TW(TASK_W)) u_pick (
    .cand_i (cand),
    .prio_i (prio_flat),
    .best_o (best_id),
    .found_o(best_found)
  );

  assign do_switch = best_found && (!run_v_q || best_id != run_id_q);

  always_comb begin
    state_d  = state_q;
    prio_d   = prio_q;
    pend_d   = pend_q;
    bind_d   = bind_q;
    bvld_d   = bvld_q;
    run_id_d = run_id_q;
    run_v_d  = run_v_q;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_CREATE: begin
          state_d[cmd_task_i] = ST_READY;
          prio_d[cmd_task_i]  = cmd_arg_i[PRIO_W-1:0];
          pend_d[cmd_task_i]  = 1'b0;
          if (run_v_q && run_id_q == cmd_task_i) run_v_d = 1'b0;
        end
        OP_WAIT: begin
          if (run_v_q) begin
            run_v_d = 1'b0;
            if (pend_q[run_id_q]) begin
              state_d[run_id_q] = ST_READY;
              pend_d[run_id_q]  = 1'b0;
            end else begin
              state_d[run_id_q] = ST_WAIT;
            end
          end
        end
        OP_BIND: begin
          bind_d[cmd_arg_i[IRQ_W-1:0]] = cmd_task_i;
          bvld_d[cmd_arg_i[IRQ_W-1:0]] = 1'b1;
        end
        OP_ACK: begin
          if (do_switch) begin
            if (run_v_q) state_d[run_id_q] = ST_READY;
            state_d[best_id] = ST_RUN;
            run_id_d = best_id;
            run_v_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
    // pin events see the post-command state
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (rise[n] && bvld_q[n]) begin
        if (state_d[bind_q[n]] == ST_WAIT) state_d[bind_q[n]] = ST_READY;
        else                               pend_d[bind_q[n]]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_TASKS; i++) begin
        state_q[i] <= ST_WAIT;
        prio_q[i]  <= '0;
      end
      for (int n = 0; n < NUM_IRQ; n++) bind_q[n] <= '0;
      pend_q   <= '0;
      bvld_q   <= '0;
      run_id_q <= '0;
      run_v_q  <= 1'b0;
      rd_q     <= '0;
    end else begin
      state_q  <= state_d;
      prio_q   <= prio_d;
      bind_q   <= bind_d;
      pend_q   <= pend_d;
      bvld_q   <= bvld_d;
      run_id_q <= run_id_d;
      run_v_q  <= run_v_d;
      if (cmd_valid_i && cmd_op_i == OP_READ) rd_q <= {~best_found, best_id};
    end
  end

  assign rd_data_o    = rd_q;
  assign switch_irq_o = do_switch;
  assign idle_o       = ~best_found;
  assign run_task_o   = run_id_q;
  assign run_valid_o  = run_v_q;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int TASK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [TASK_W:0]   rd_data_o,
  input logic              switch_irq_o,
  input logic              idle_o,
  input logic [TASK_W-1:0] run_task_o,
  input logic              run_valid_o,
  input logic [TASK_W-1:0] best_id
);
  // R11
  no_switch_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(switch_irq_o && idle_o));

  // R5
  ack_takes_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd5 && switch_irq_o)
    |=> (run_valid_o && run_task_o == $past(best_id)));

  // R6
  wait_drops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd2) |=> !run_valid_o);

  // R4
  read_returns_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd4) |=> rd_data_o == $past({idle_o, best_id}));

  // R9
  run_only_by_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(run_task_o) && $stable(run_valid_o)));
endmodule

bind hw_task_sched sched_chk #(.TASK_W(TASK_W)) u_sched_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .rd_data_o   (rd_data_o),
  .switch_irq_o(switch_irq_o),
  .idle_o      (idle_o),
  .run_task_o  (run_task_o),
  .run_valid_o (run_valid_o),
  .best_id     (best_id)
);

// File: tb/tb_hw_task_sched.sv
module tb_hw_task_sched;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_task = '0;
  logic [2:0] cmd_arg = '0;
  logic [4:0] rd_data;
  logic       switch_irq, idle, run_valid;
  logic [3:0] run_task;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_task_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_task_i(cmd_task), .cmd_arg_i(cmd_arg),
    .rd_data_o(rd_data), .switch_irq_o(switch_irq), .idle_o(idle),
    .run_task_o(run_task), .run_valid_o(run_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] t, input logic [2:0] a);
    cmd_op = op; cmd_task = t; cmd_arg = a; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic read_next(output logic [4:0] v);
    cmd(3'd4, 4'd0, 3'd0);
    v = rd_data;
  endtask

  task automatic pulse_irq(input int n);
    irq[n] = 1'b1;
    repeat (2) @(negedge clk);
    irq[n] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [4:0] v;
    chk_eq("R1 idle", idle, 1);
    chk_eq("R1 switch", switch_irq, 0);
    chk_eq("R1 run_valid", run_valid, 0);
    read_next(v);
    chk_eq("R1 R4 read idle bit", v[4], 1);
  endtask

  task automatic t_select;
    logic [4:0] v;
    cmd(3'd1, 4'd5, 3'd2);
    chk_eq("R2 switch after create", switch_irq, 1);
    read_next(v);
    chk_eq("R2 R4 next", v, 5);
    cmd(3'd1, 4'd9, 3'd6);
    read_next(v);
    chk_eq("R3 higher prio", v, 9);
    cmd(3'd1, 4'd3, 3'd6);
    read_next(v);
    chk_eq("R3 tie lower id", v, 3);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R5 run task", run_task, 3);
    chk_eq("R5 run valid", run_valid, 1);
    chk_eq("R9 no switch when best runs", switch_irq, 0);
  endtask

  task automatic t_ack_ignored;
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R11 ack ignored task", run_task, 3);
    chk_eq("R11 ack ignored valid", run_valid, 1);
  endtask

  task automatic t_wait;
    logic [4:0] v;
    cmd(3'd2, 4'd0, 3'd0);
    chk_eq("R6 run valid drops", run_valid, 0);
    chk_eq("R6 switch to next", switch_irq, 1);
    read_next(v);
    chk_eq("R6 next after wait", v, 9);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R5 run 9", run_task, 9);
    cmd(3'd2, 4'd0, 3'd0);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R5 run 5", run_task, 5);
    cmd(3'd2, 4'd0, 3'd0);
    chk_eq("R6 idle", idle, 1);
    chk_eq("R11 no switch idle", switch_irq, 0);
  endtask

  task automatic t_irq;
    logic [4:0] v;
    cmd(3'd3, 4'd9, 3'd2);
    pulse_irq(5);
    chk_eq("R7 unbound pin ignored", idle, 1);
    irq[2] = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R7 bound pin wakes", switch_irq, 1);
    read_next(v);
    chk_eq("R7 next is isr task", v, 9);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R7 isr runs", run_task, 9);
    cmd(3'd2, 4'd0, 3'd0);
    repeat (5) @(negedge clk);
    chk_eq("R10 held level no re-wake", idle, 1);
    irq[2] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pending;
    logic [4:0] v;
    cmd(3'd1, 4'd5, 3'd1);
    cmd(3'd5, 4'd0, 3'd0);
    cmd(3'd3, 4'd5, 3'd1);
    pulse_irq(1);
    chk_eq("R9 running task edge no switch", switch_irq, 0);
    chk_eq("R8 still running", run_task, 5);
    cmd(3'd2, 4'd0, 3'd0);
    chk_eq("R8 pending keeps ready", idle, 0);
    chk_eq("R8 switch after wait", switch_irq, 1);
    read_next(v);
    chk_eq("R8 next", v, 5);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R8 rerun", run_task, 5);
  endtask

  task automatic t_preempt;
    logic [4:0] v;
    cmd(3'd3, 4'd3, 3'd0);
    pulse_irq(0);
    chk_eq("R9 preempt switch", switch_irq, 1);
    read_next(v);
    chk_eq("R9 preempt next", v, 3);
    cmd(3'd5, 4'd0, 3'd0);
    chk_eq("R9 preempted run", run_task, 3);
    cmd(3'd2, 4'd0, 3'd0);
    read_next(v);
    chk_eq("R5 previous returned ready", v, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_ack_ignored();
    t_wait();
    t_irq();
    t_pending();
    t_preempt();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule